// File: doc/BRIEF.md
# Oversampled Serial Receiver with Flag-Carrying Receive Queue

This block turns an asynchronous serial line into a queue of received bytes. The line input is first passed through a two-stage synchronizer. A falling edge starts a frame, and a 16x oversampling enable (`os_tick`) sets the timing of every bit. The start bit is checked again at its middle. After it come eight data bits, one parity bit and one stop bit, each sampled at the middle of its bit period.

Every completed frame is written into a 16-deep queue as a 10-bit word. The word holds the byte plus two error flags, one for a parity mismatch and one for a stop bit received as 0. Each flag belongs to its own byte only; there is no shared status bit that later frames could overwrite. The host pops one word per `pop` pulse and can see how many words are waiting on a 5-bit occupancy output.

The host picks, per frame, whether the first data bit on the line becomes the lowest or the highest bit of the byte. It also picks even or odd parity. A frame that completes while the queue is full is discarded, and a sticky overflow flag is raised.

Top module: `uart_rx_fifo`

## Requirements
- R1: The line input goes through two flip-flops before any sampling. A falling edge begins a frame only if the line is still low at the middle of the start bit (eighth oversampling tick). A shorter low pulse is discarded without producing a queue entry.
- R2: With `msb_order`=0, latched when the start edge is seen, the first data bit after the start bit lands in bit 0 of the byte.
- R3: With `msb_order`=1, the first data bit after the start bit lands in bit 7 of the byte.
- R4: Parity is checked on every frame. With `odd_par`=0 the eight data bits plus the parity bit must hold an even number of ones; with `odd_par`=1 they must hold an odd number. A mismatch sets bit 8 of that frame's entry only.
- R5: A stop bit sampled as 0 sets bit 9 of that frame's entry only. The data bits are still stored.
- R6: Each entry read on `pop_word` is laid out as {stop error [9], parity error [8], byte [7:0]}. Entries are returned in arrival order.
- R7: `fill` rises by one for each stored frame and falls by one for each pop of a non-empty queue. A store and a pop in the same cycle leave it unchanged. It never exceeds 16.
- R8: A pop while `fill` is 0 leaves `pop_word` and `fill` unchanged.
- R9: A frame that completes while `fill` is 16 is dropped: `fill` stays 16 and the stored entries are unchanged. It also sets `ovf`, which stays set until reset.
- R10: After reset, `fill` is 0, `pop_word` is 0, `ovf` is 0 and the receiver waits for a start edge.
- R11: Bit timing advances only on cycles with `os_tick`=1. One bit period is 16 ticks, whatever the spacing of the ticks in clock cycles.
- R12: `pop_word` is updated on the clock edge that samples `pop`, so the popped word is valid in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 1 | Asynchronous serial input, idle high |
| os_tick | input | 1 | Oversampling enable, 16 pulses per bit |
| msb_order | input | 1 | 1: first data bit is the byte's MSB |
| odd_par | input | 1 | 1: odd parity expected, 0: even parity |
| pop | input | 1 | Pop one entry from the queue |
| pop_word | output | 10 | Last popped entry {ferr, perr, byte} |
| fill | output | 5 | Number of entries waiting |
| ovf | output | 1 | Sticky flag: a frame was dropped because the queue was full |

## Verification
The receiver is driven with asymmetric bytes such as 0x1E and 0xC4, so that a bit-reversal or an off-by-one sampling position shows up as a different value. One fixed line pattern is sent once with each bit order, which shows that the order control reverses the byte. Frames with a wrong parity bit or a low stop bit are each followed by a clean frame, which separates a flag stored per byte from a flag that leaks into later entries; both parity senses are covered. A short low glitch, a run of frames that overfills the queue, pops of an empty queue and a pass with ticks on every other clock cover start rejection, overflow dropping and ordering, read-side stability, and tick-driven timing.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    localparam int DATA_W  = 8;
    localparam int ENTRY_W = DATA_W + 2;

    typedef struct packed {
        logic              ferr;
        logic              perr;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign dout = sync_q[STAGES-1];
endmodule

// File: rtl/rx_framer.sv
module rx_framer
    import uart_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      rx_s,
    input  logic      msb_order,
    input  logic      odd_par,
    output logic      push,
    output rx_entry_t push_entry
);
    localparam int OVS_W = $clog2(OVS);
    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [OVS_W-1:0] MID_C  = OVS_W'(OVS / 2 - 1);
    localparam logic [OVS_W-1:0] LAST_C = OVS_W'(OVS - 1);
    localparam logic [BIT_W-1:0] BLAST  = BIT_W'(DATA_W - 1);

    typedef struct packed {
        rx_state_e         state;
        logic [OVS_W-1:0]  ovs;
        logic [BIT_W-1:0]  bidx;
        logic [DATA_W-1:0] shreg;
        logic              pbit;
        logic              msb;
        logic              odd;
        logic              prev;
        logic              push;
        rx_entry_t         entry;
    } fr_t;

    fr_t fr_d, fr_q;

    always_comb begin
        fr_d      = fr_q;
        fr_d.push = 1'b0;
        fr_d.prev = rx_s;
        case (fr_q.state)
            ST_IDLE: begin
                if (fr_q.prev && !rx_s) begin
                    fr_d.state = ST_START;
                    fr_d.ovs   = '0;
                    fr_d.msb   = msb_order;
                    fr_d.odd   = odd_par;
                end
            end
            ST_START: begin
                if (tick) begin
                    if (fr_q.ovs == MID_C) begin
                        fr_d.ovs  = '0;
                        fr_d.bidx = '0;
                        fr_d.state = rx_s ? ST_IDLE : ST_DATA;
                    end else begin
                        fr_d.ovs = fr_q.ovs + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (tick) begin
                    if (fr_q.ovs == LAST_C) begin
                        fr_d.ovs = '0;
                        if (fr_q.msb) fr_d.shreg = {fr_q.shreg[DATA_W-2:0], rx_s};
                        else          fr_d.shreg = {rx_s, fr_q.shreg[DATA_W-1:1]};
                        if (fr_q.bidx == BLAST) fr_d.state = ST_PAR;
                        else                    fr_d.bidx  = fr_q.bidx + 1'b1;
                    end else begin
                        fr_d.ovs = fr_q.ovs + 1'b1;
                    end
                end
            end
            ST_PAR: begin
                if (tick) begin
                    if (fr_q.ovs == LAST_C) begin
                        fr_d.ovs   = '0;
                        fr_d.pbit  = rx_s;
                        fr_d.state = ST_STOP;
                    end else begin
                        fr_d.ovs = fr_q.ovs + 1'b1;
                    end
                end
            end
            ST_STOP: begin
                if (tick) begin
                    if (fr_q.ovs == LAST_C) begin
                        fr_d.ovs        = '0;
                        fr_d.push       = 1'b1;
                        fr_d.entry.data = fr_q.shreg;
                        fr_d.entry.perr = (^fr_q.shreg) ^ fr_q.pbit ^ fr_q.odd;
                        fr_d.entry.ferr = !rx_s;
                        fr_d.state      = ST_IDLE;
                    end else begin
                        fr_d.ovs = fr_q.ovs + 1'b1;
                    end
                end
            end
            default: fr_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fr_q       <= '0;
            fr_q.state <= ST_IDLE;
            fr_q.prev  <= 1'b1;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign push       = fr_q.push;
    assign push_entry = fr_q.entry;
endmodule

// File: rtl/rx_queue.sv
module rx_queue
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  rx_entry_t     push_entry,
    input  logic          pop,
    output rx_entry_t     pop_entry,
    output logic [CW-1:0] fill,
    output logic          ovf
);
    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

    typedef struct packed {
        rx_entry_t [DEPTH-1:0] mem;
        logic [AW-1:0]         wptr;
        logic [AW-1:0]         rptr;
        logic [CW-1:0]         cnt;
        rx_entry_t             rout;
        logic                  ovf;
    } q_t;

    q_t   q_d, q_q;
    logic do_wr, do_rd;

    always_comb begin
        q_d   = q_q;
        do_wr = push && (q_q.cnt != FULL_C);
        do_rd = pop && (q_q.cnt != '0);
        if (push && !do_wr) q_d.ovf = 1'b1;
        if (do_wr) begin
            q_d.mem[q_q.wptr] = push_entry;
            q_d.wptr          = q_q.wptr + 1'b1;
        end
        if (do_rd) begin
            q_d.rout = q_q.mem[q_q.rptr];
            q_d.rptr = q_q.rptr + 1'b1;
        end
        case ({do_wr, do_rd})
            2'b10:   q_d.cnt = q_q.cnt + 1'b1;
            2'b01:   q_d.cnt = q_q.cnt - 1'b1;
            default: q_d.cnt = q_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign pop_entry = q_q.rout;
    assign fill      = q_q.cnt;
    assign ovf       = q_q.ovf;
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int OVS   = 16,
    parameter int DEPTH = 16,
    parameter int SYNC  = 2,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_in,
    input  logic               os_tick,
    input  logic               msb_order,
    input  logic               odd_par,
    input  logic               pop,
    output logic [ENTRY_W-1:0] pop_word,
    output logic [CNT_W-1:0]   fill,
    output logic               ovf
);
    logic      rx_s;
    logic      fr_push;
    rx_entry_t fr_entry;
    rx_entry_t q_out;

    rx_sync #(.STAGES(SYNC)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (line_in),
        .dout (rx_s)
    );

    rx_framer #(.OVS(OVS)) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (os_tick),
        .rx_s      (rx_s),
        .msb_order (msb_order),
        .odd_par   (odd_par),
        .push      (fr_push),
        .push_entry(fr_entry)
    );

    rx_queue #(.DEPTH(DEPTH)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (fr_push),
        .push_entry(fr_entry),
        .pop       (pop),
        .pop_entry (q_out),
        .fill      (fill),
        .ovf       (ovf)
    );

    assign pop_word = q_out;
endmodule

// File: rtl/uart_rx_fifo_chk.sv
module uart_rx_fifo_chk #(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pop,
    input logic             push,
    input logic [9:0]       pop_word,
    input logic [CNT_W-1:0] fill,
    input logic             ovf
);
    localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);

    // R7
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FULL_C);

    // R7
    fill_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && fill != FULL_C) |=> fill == $past(fill) + 1'b1);

    // R7
    fill_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && fill != '0 && fill != FULL_C) |=> $stable(fill));

    // R7
    fill_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!push && !pop) |=> $stable(fill));

    // R8
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && fill == '0) |=> ($stable(fill) && $stable(pop_word)));

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);

    // R9
    drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && fill == FULL_C) |=> (ovf && fill == FULL_C));
endmodule

bind uart_rx_fifo uart_rx_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pop     (pop),
    .push    (fr_push),
    .pop_word(pop_word),
    .fill    (fill),
    .ovf     (ovf)
);

// File: tb/uart_rx_fifo_test.sv
module uart_rx_fifo_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_in = 1'b1;
    logic       os_tick = 1'b1;
    logic       msb_order = 1'b0;
    logic       odd_par = 1'b0;
    logic       pop = 1'b0;
    logic [9:0] pop_word;
    logic [4:0] fill;
    logic       ovf;
    logic       slow = 1'b0;
    int         n_chk = 0;
    int         n_fail = 0;
    int         per = 16;

    always #5 clk = ~clk;

    uart_rx_fifo uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_in  (line_in),
        .os_tick  (os_tick),
        .msb_order(msb_order),
        .odd_par  (odd_par),
        .pop      (pop),
        .pop_word (pop_word),
        .fill     (fill),
        .ovf      (ovf)
    );

    always @(negedge clk) begin
        if (slow) os_tick <= ~os_tick;
        else      os_tick <= 1'b1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold(input logic v);
        line_in = v;
        repeat (per) @(negedge clk);
    endtask

    // sends a frame; the bit order on the line follows line_msb
    task automatic send(input logic [7:0] d, input logic line_msb, input logic podd,
                        input logic bad_par, input logic bad_stop);
        hold(1'b0);
        for (int i = 0; i < 8; i++) hold(line_msb ? d[7-i] : d[i]);
        hold((^d) ^ podd ^ bad_par);
        hold(!bad_stop);
        hold(1'b1);
        hold(1'b1);
    endtask

    task automatic pop_one(output logic [9:0] v);
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
        v = pop_word;
    endtask

    task automatic t_reset();
        chk("R10 fill", 32'(fill), 0);
        chk("R10 pop_word", 32'(pop_word), 0);
        chk("R10 ovf", 32'(ovf), 0);
    endtask

    task automatic t_lsb();
        logic [9:0] v;
        msb_order = 1'b0;
        send(8'h1E, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R7 fill after frame", 32'(fill), 1);
        pop_one(v);
        chk("R2 R6 R12 lsb-first entry", 32'(v), 32'h01E);
        chk("R7 fill after pop", 32'(fill), 0);
    endtask

    task automatic t_msb();
        logic [9:0] v;
        msb_order = 1'b1;
        send(8'hC4, 1'b1, 1'b0, 1'b0, 1'b0);
        pop_one(v);
        chk("R3 msb-first entry", 32'(v), 32'h0C4);
        send(8'h1E, 1'b0, 1'b0, 1'b0, 1'b0);
        pop_one(v);
        chk("R3 same line read msb-first is reversed", 32'(v), 32'h078);
        msb_order = 1'b0;
    endtask

    task automatic t_parity();
        logic [9:0] v;
        send(8'h37, 1'b0, 1'b0, 1'b1, 1'b0);
        send(8'h37, 1'b0, 1'b0, 1'b0, 1'b0);
        pop_one(v);
        chk("R4 even parity error flagged", 32'(v), 32'h137);
        pop_one(v);
        chk("R4 next entry clean", 32'(v), 32'h037);
        odd_par = 1'b1;
        send(8'h5A, 1'b0, 1'b1, 1'b0, 1'b0);
        pop_one(v);
        chk("R4 odd parity accepted", 32'(v), 32'h05A);
        send(8'h5A, 1'b0, 1'b0, 1'b0, 1'b0);
        pop_one(v);
        chk("R4 odd parity mismatch", 32'(v), 32'h15A);
        odd_par = 1'b0;
    endtask

    task automatic t_framing();
        logic [9:0] v;
        send(8'h81, 1'b0, 1'b0, 1'b0, 1'b1);
        send(8'h42, 1'b0, 1'b0, 1'b0, 1'b0);
        pop_one(v);
        chk("R5 stop error flagged", 32'(v), 32'h281);
        pop_one(v);
        chk("R5 next entry clean", 32'(v), 32'h042);
    endtask

    task automatic t_glitch();
        logic [9:0] v;
        line_in = 1'b0;
        repeat (4) @(negedge clk);
        line_in = 1'b1;
        repeat (300) @(negedge clk);
        chk("R1 glitch discarded", 32'(fill), 0);
        send(8'h6C, 1'b0, 1'b0, 1'b0, 1'b0);
        pop_one(v);
        chk("R1 frame after glitch", 32'(v), 32'h06C);
    endtask

    task automatic t_empty_pop();
        logic [9:0] v;
        pop_one(v);
        chk("R8 empty pop keeps word", 32'(v), 32'h06C);
        chk("R8 empty pop keeps fill", 32'(fill), 0);
    endtask

    task automatic t_full();
        logic [9:0] v;
        for (int i = 0; i < 17; i++) send(8'(i + 8'h10), 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R9 fill saturates", 32'(fill), 16);
        chk("R9 ovf set", 32'(ovf), 1);
        for (int i = 0; i < 16; i++) begin
            pop_one(v);
            chk("R6 R9 order and content", 32'(v), 32'(i + 8'h10));
        end
        chk("R7 fill drained", 32'(fill), 0);
        chk("R9 ovf sticky", 32'(ovf), 1);
    endtask

    task automatic t_slow_tick();
        logic [9:0] v;
        slow = 1'b1;
        per = 32;
        send(8'hB3, 1'b0, 1'b0, 1'b0, 1'b0);
        pop_one(v);
        chk("R11 sparse ticks", 32'(v), 32'h0B3);
        slow = 1'b0;
        per = 16;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL R10 watchdog actual=timeout expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lsb();
        t_msb();
        t_parity();
        t_framing();
        t_glitch();
        t_empty_pop();
        t_slow_tick();
        t_full();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule